// File: doc/BRIEF.md
# Operand Shifter with Carry Output

This block is a purely combinational 32-bit shifter that sits in front of the second ALU input. It takes an operand, a shift kind, a shift amount and the current carry flag. It returns the shifted operand together with the carry that the shift produces. That carry can then feed the flag update for logical instructions.

The amount comes from one of two places. It is either a 5-bit immediate field or the low byte of a register, chosen by a select line. The register-supplied amount can reach 255, so the block has explicit rules for amounts of 32 and above. An immediate of zero leaves the operand and carry untouched. A separate rotate-through-carry-by-one kind moves the incoming carry into the top bit. A pass-through line routes an already-formed immediate operand around the shifter and keeps the carry as it was.

There are no states or transitions. The output is a function of the current inputs only, selected among four unit results by the shift kind.

Top module: `operand_shifter`

## Requirements
- R1: Kind code 0 shifts left logically by 1..31, filling with zeros; carry_out is the last bit moved out (for 0x8000_0004 by 1: value 0x0000_0008, carry 1). A shift by 3 multiplies by 8.
- R2: Kind code 1 shifts right logically by 1..31, filling with zeros; carry_out is operand bit (amount-1).
- R3: Kind code 2 shifts right arithmetically by 1..31, filling with copies of bit 31; carry_out is operand bit (amount-1).
- R4: Kind code 3 rotates right by 1..31; carry_out equals the new bit 31.
- R5: Kind code 4 (rotate through carry) ignores the amount and shifts right by one: carry_in goes to bit 31 and carry_out is the old bit 0.
- R6: For kind codes 0..3, an effective amount of 0 returns the operand unchanged with carry_out equal to carry_in.
- R7: For a register-supplied amount, a logical shift of exactly 32 gives 0 with carry_out = bit 0 (left) or bit 31 (right). Amounts of 33..255 give 0 with carry_out 0.
- R8: An arithmetic right shift by 32..255 sets every bit to bit 31, and carry_out equals bit 31.
- R9: A register-supplied rotate uses the amount modulo 32. A non-zero multiple of 32 returns the operand unchanged with carry_out = bit 31.
- R10: When pass_thru is 1, the operand and carry_in appear unchanged at the outputs for any kind and amount.
- R11: amt_from_reg = 0 uses imm_amt and ignores reg_amt; amt_from_reg = 1 uses reg_amt and ignores imm_amt.
- R12: Kind codes 5..7 pass the operand and carry_in through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_in | input | 32 | Operand to shift |
| sh_kind | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 8 | Low byte of the register holding the amount |
| amt_from_reg | input | 1 | 1 selects reg_amt, 0 selects imm_amt |
| pass_thru | input | 1 | Bypass for an already-formed immediate operand |
| carry_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Each kind is driven with operands whose top bit, bottom bit and the bit next to the cut differ. This makes a wrong fill value, a wrong shift direction or an off-by-one carry index produce a distinct output.

Register-supplied amounts are taken to 0, 32, 33, 40, 64 and 200. These values separate the exact-width rule from the beyond-width rule and the modulo rotate. Both carry_in values are used where the carry should pass through, so a carry that is held low or high is caught.

Amount-source tests load conflicting values into the unused amount field, so selecting the wrong source gives a visibly different result.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
    typedef enum logic [2:0] {
        KIND_LSL = 3'd0,
        KIND_LSR = 3'd1,
        KIND_ASR = 3'd2,
        KIND_ROR = 3'd3,
        KIND_RRX = 3'd4
    } shift_kind_e;
endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel #(
    parameter int IMM_W = 5,
    parameter int AMT_W = 8
) (
    input  logic [IMM_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    input  logic             amt_from_reg,
    output logic [AMT_W-1:0] eff_amt,
    output logic             amt_zero
);
    always_comb begin
        if (amt_from_reg) eff_amt = reg_amt;
        else              eff_amt = AMT_W'(imm_amt);
        amt_zero = (eff_amt == '0);
    end
endmodule

// File: rtl/shf_left_unit.sv
module shf_left_unit #(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     x,
    input  logic [AMT_W-1:0] amt,
    input  logic             cin,
    output logic [W-1:0]     y,
    output logic             cout
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(W);
    logic [W:0] ext;

    always_comb begin
        ext = {1'b0, x} << amt;
        if (amt == '0) begin
            y    = x;
            cout = cin;
        end else if (amt > FULL) begin
            y    = '0;
            cout = 1'b0;
        end else begin
            y    = ext[W-1:0];
            cout = ext[W];
        end
    end
endmodule

// File: rtl/shf_right_unit.sv
module shf_right_unit #(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    parameter bit ARITH = 1'b0
) (
    input  logic [W-1:0]     x,
    input  logic [AMT_W-1:0] amt,
    input  logic             cin,
    output logic [W-1:0]     y,
    output logic             cout
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(W);
    logic [W:0] ext;
    logic       sgn;

    always_comb begin
        sgn = x[W-1];
        if (ARITH) ext = $unsigned($signed({x, 1'b0}) >>> amt);
        else       ext = {x, 1'b0} >> amt;
        if (amt == '0) begin
            y    = x;
            cout = cin;
        end else if (ARITH && amt >= FULL) begin
            y    = {W{sgn}};
            cout = sgn;
        end else if (amt > FULL) begin
            y    = '0;
            cout = 1'b0;
        end else begin
            y    = ext[W:1];
            cout = ext[0];
        end
    end
endmodule

// File: rtl/shf_rotate_unit.sv
module shf_rotate_unit #(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [W-1:0]     x,
    input  logic [AMT_W-1:0] amt,
    input  logic             cin,
    output logic [W-1:0]     y,
    output logic             cout,
    output logic [W-1:0]     ext_y,
    output logic             ext_cout
);
    localparam int RW = $clog2(W);
    logic [RW-1:0]  rot;
    logic [2*W-1:0] dbl;

    always_comb begin
        rot = amt[RW-1:0];
        dbl = {x, x} >> rot;
        if (amt == '0) begin
            y    = x;
            cout = cin;
        end else if (rot == '0) begin
            y    = x;
            cout = x[W-1];
        end else begin
            y    = dbl[W-1:0];
            cout = dbl[W-1];
        end
        ext_y    = {cin, x[W-1:1]};
        ext_cout = x[0];
    end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter #(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    localparam int IMM_W = $clog2(W)
) (
    input  logic [W-1:0]     opnd_in,
    input  logic [2:0]       sh_kind,
    input  logic [IMM_W-1:0] imm_amt,
    input  logic [AMT_W-1:0] reg_amt,
    input  logic             amt_from_reg,
    input  logic             pass_thru,
    input  logic             carry_in,
    output logic [W-1:0]     opnd_out,
    output logic             carry_out
);
    import shifter_pkg::*;

    localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

    shift_kind_e      kind;
    logic [AMT_W-1:0] eff_amt;
    logic             amt_zero;
    logic [W-1:0]     lsl_y, lsr_y, asr_y, ror_y, rrx_y;
    logic             lsl_c, lsr_c, asr_c, ror_c, rrx_c;

    assign kind = shift_kind_e'(sh_kind);

    shf_amount_sel #(.IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
        .imm_amt(imm_amt), .reg_amt(reg_amt), .amt_from_reg(amt_from_reg),
        .eff_amt(eff_amt), .amt_zero(amt_zero)
    );

    shf_left_unit #(.W(W), .AMT_W(AMT_W)) u_lsl (
        .x(opnd_in), .amt(eff_amt), .cin(carry_in), .y(lsl_y), .cout(lsl_c)
    );

    for (genvar g = 0; g < 2; g++) begin : g_right
        logic [W-1:0] ry;
        logic         rc;
        shf_right_unit #(.W(W), .AMT_W(AMT_W), .ARITH(g == 1)) u_rs (
            .x(opnd_in), .amt(eff_amt), .cin(carry_in), .y(ry), .cout(rc)
        );
    end
    assign lsr_y = g_right[0].ry;
    assign lsr_c = g_right[0].rc;
    assign asr_y = g_right[1].ry;
    assign asr_c = g_right[1].rc;

    shf_rotate_unit #(.W(W), .AMT_W(AMT_W)) u_ror (
        .x(opnd_in), .amt(eff_amt), .cin(carry_in), .y(ror_y), .cout(ror_c),
        .ext_y(rrx_y), .ext_cout(rrx_c)
    );

    always_comb begin
        if (pass_thru) begin
            opnd_out  = opnd_in;
            carry_out = carry_in;
        end else begin
            unique case (kind)
                KIND_LSL: begin opnd_out = lsl_y; carry_out = lsl_c; end
                KIND_LSR: begin opnd_out = lsr_y; carry_out = lsr_c; end
                KIND_ASR: begin opnd_out = asr_y; carry_out = asr_c; end
                KIND_ROR: begin opnd_out = ror_y; carry_out = ror_c; end
                KIND_RRX: begin opnd_out = rrx_y; carry_out = rrx_c; end
                default:  begin opnd_out = opnd_in; carry_out = carry_in; end
            endcase
        end
    end

    always_comb begin
        // R10
        pass_keep_chk: assert (!pass_thru || (opnd_out == opnd_in && carry_out == carry_in));
        // R6
        zero_amt_chk: assert (pass_thru || !amt_zero || sh_kind > 3'd3
                              || (opnd_out == opnd_in && carry_out == carry_in));
        // R5
        rrx_in_chk: assert (pass_thru || kind != KIND_RRX
                            || (opnd_out[W-1] == carry_in && carry_out == opnd_in[0]));
        // R8
        asr_fill_chk: assert (pass_thru || kind != KIND_ASR || eff_amt < FULL
                              || (opnd_out == {W{opnd_in[W-1]}} && carry_out == opnd_in[W-1]));
        // R7
        lsl_over_chk: assert (pass_thru || kind != KIND_LSL || eff_amt <= FULL
                              || (opnd_out == '0 && !carry_out));
        // R9
        ror_wrap_chk: assert (pass_thru || kind != KIND_ROR || amt_zero
                              || eff_amt[IMM_W-1:0] != '0 || opnd_out == opnd_in);
    end
endmodule

// File: tb/test_operand_shifter.sv
module test_operand_shifter;
    logic        clk = 1'b0;
    logic [31:0] opnd_in = '0;
    logic [2:0]  sh_kind = '0;
    logic [4:0]  imm_amt = '0;
    logic [7:0]  reg_amt = '0;
    logic        amt_from_reg = 1'b0;
    logic        pass_thru = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] opnd_out;
    logic        carry_out;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    operand_shifter i_operand_shifter (
        .opnd_in(opnd_in), .sh_kind(sh_kind), .imm_amt(imm_amt), .reg_amt(reg_amt),
        .amt_from_reg(amt_from_reg), .pass_thru(pass_thru), .carry_in(carry_in),
        .opnd_out(opnd_out), .carry_out(carry_out)
    );

    task automatic apply(input logic [31:0] v, input logic [2:0] k, input logic [4:0] ia,
                         input logic [7:0] ra, input logic fr, input logic pt, input logic ci);
        @(posedge clk);
        opnd_in = v; sh_kind = k; imm_amt = ia; reg_amt = ra;
        amt_from_reg = fr; pass_thru = pt; carry_in = ci;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] ev, input logic ec);
        n_run++;
        if (opnd_out !== ev || carry_out !== ec) begin
            n_fail++;
            $display("FAIL %s: got value %h carry %b, expected value %h carry %b",
                     req, opnd_out, carry_out, ev, ec);
        end
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R6 idle zero inputs", 32'h0, 1'b0);
    endtask

    task automatic t_left;
        apply(32'h8000_0004, 3'd0, 5'd1, 8'd0, 1'b0, 1'b0, 1'b0); check("R1 lsl 1", 32'h0000_0008, 1'b1);
        apply(32'h0000_0005, 3'd0, 5'd3, 8'd0, 1'b0, 1'b0, 1'b1); check("R1 lsl 3 times 8", 32'h0000_0028, 1'b0);
        apply(32'hF000_0001, 3'd0, 5'd0, 8'd4, 1'b1, 1'b0, 1'b0); check("R1 lsl reg 4", 32'h0000_0010, 1'b1);
    endtask

    task automatic t_right;
        apply(32'h0000_00F1, 3'd1, 5'd4, 8'd0, 1'b0, 1'b0, 1'b1); check("R2 lsr 4", 32'h0000_000F, 1'b0);
        apply(32'h8000_0003, 3'd1, 5'd1, 8'd0, 1'b0, 1'b0, 1'b0); check("R2 lsr 1", 32'h4000_0001, 1'b1);
        apply(32'h8000_0010, 3'd2, 5'd4, 8'd0, 1'b0, 1'b0, 1'b1); check("R3 asr 4", 32'hF800_0001, 1'b0);
        apply(32'h8000_0010, 3'd2, 5'd5, 8'd0, 1'b0, 1'b0, 1'b0); check("R3 asr 5", 32'hFC00_0000, 1'b1);
        apply(32'h4000_0010, 3'd2, 5'd5, 8'd0, 1'b0, 1'b0, 1'b0); check("R3 asr positive", 32'h0200_0000, 1'b1);
    endtask

    task automatic t_rotate;
        apply(32'h0000_0001, 3'd3, 5'd1, 8'd0, 1'b0, 1'b0, 1'b0); check("R4 ror 1", 32'h8000_0000, 1'b1);
        apply(32'h1234_5678, 3'd3, 5'd8, 8'd0, 1'b0, 1'b0, 1'b1); check("R4 ror 8", 32'h7812_3456, 1'b0);
        apply(32'h0000_0003, 3'd4, 5'd7, 8'd0, 1'b0, 1'b0, 1'b1); check("R5 rrx cin 1", 32'h8000_0001, 1'b1);
        apply(32'h0000_0002, 3'd4, 5'd0, 8'd9, 1'b1, 1'b0, 1'b0); check("R5 rrx cin 0", 32'h0000_0001, 1'b0);
    endtask

    task automatic t_zero;
        apply(32'h0000_ABCD, 3'd1, 5'd0, 8'd0, 1'b0, 1'b0, 1'b1); check("R6 lsr imm 0", 32'h0000_ABCD, 1'b1);
        apply(32'h8000_0001, 3'd2, 5'd0, 8'd0, 1'b1, 1'b0, 1'b0); check("R6 asr reg 0", 32'h8000_0001, 1'b0);
        apply(32'h8000_0001, 3'd3, 5'd0, 8'd0, 1'b0, 1'b0, 1'b1); check("R6 ror imm 0", 32'h8000_0001, 1'b1);
    endtask

    task automatic t_wide;
        apply(32'h0000_0001, 3'd0, 5'd0, 8'd32, 1'b1, 1'b0, 1'b0); check("R7 lsl 32", 32'h0, 1'b1);
        apply(32'hFFFF_FFFF, 3'd0, 5'd0, 8'd33, 1'b1, 1'b0, 1'b1); check("R7 lsl 33", 32'h0, 1'b0);
        apply(32'h8000_0000, 3'd1, 5'd0, 8'd32, 1'b1, 1'b0, 1'b0); check("R7 lsr 32", 32'h0, 1'b1);
        apply(32'hFFFF_FFFF, 3'd1, 5'd0, 8'd200, 1'b1, 1'b0, 1'b1); check("R7 lsr 200", 32'h0, 1'b0);
        apply(32'h8000_0000, 3'd2, 5'd0, 8'd40, 1'b1, 1'b0, 1'b0); check("R8 asr 40 neg", 32'hFFFF_FFFF, 1'b1);
        apply(32'h7FFF_FFFF, 3'd2, 5'd0, 8'd32, 1'b1, 1'b0, 1'b1); check("R8 asr 32 pos", 32'h0, 1'b0);
    endtask

    task automatic t_modrot;
        apply(32'h1234_5678, 3'd3, 5'd0, 8'd40, 1'b1, 1'b0, 1'b1); check("R9 ror 40", 32'h7812_3456, 1'b0);
        apply(32'h8000_0001, 3'd3, 5'd0, 8'd64, 1'b1, 1'b0, 1'b0); check("R9 ror 64", 32'h8000_0001, 1'b1);
        apply(32'h0000_0001, 3'd3, 5'd0, 8'd32, 1'b1, 1'b0, 1'b1); check("R9 ror 32", 32'h0000_0001, 1'b0);
    endtask

    task automatic t_misc;
        apply(32'hDEAD_BEEF, 3'd0, 5'd4, 8'd0, 1'b0, 1'b1, 1'b1); check("R10 bypass lsl", 32'hDEAD_BEEF, 1'b1);
        apply(32'hDEAD_BEEF, 3'd4, 5'd0, 8'd0, 1'b0, 1'b1, 1'b0); check("R10 bypass rrx", 32'hDEAD_BEEF, 1'b0);
        apply(32'h0000_0001, 3'd0, 5'd1, 8'd8, 1'b0, 1'b0, 1'b0); check("R11 imm source", 32'h0000_0002, 1'b0);
        apply(32'h0000_0001, 3'd0, 5'd1, 8'd8, 1'b1, 1'b0, 1'b0); check("R11 reg source", 32'h0000_0100, 1'b0);
        apply(32'h0000_0055, 3'd6, 5'd3, 8'd3, 1'b0, 1'b0, 1'b1); check("R12 code 6", 32'h0000_0055, 1'b1);
        apply(32'h0000_0055, 3'd7, 5'd3, 8'd3, 1'b1, 1'b0, 1'b0); check("R12 code 7", 32'h0000_0055, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_idle();
        t_left();
        t_right();
        t_rotate();
        t_zero();
        t_wide();
        t_modrot();
        t_misc();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule